// File: doc/BRIEF.md
# FIFO Pattern and Count Monitor

This block watches one port of a shared byte FIFO. The FIFO storage lives outside. On every cycle in which the FIFO reports a completed move (`upd`), the block takes in the new queue length, the full and empty status and the byte that was moved. It keeps a byte count that can be frozen. It stores the moved byte and compares it with a pattern under a don't-care mask. It compares the queue length with a 7-bit threshold. It raises sticky pending bits that an interrupt controller can collect.

The port also reports access attempts (`rd_try`, `wr_try`). A read attempted while the FIFO is empty, or a write attempted while it is full, is illegal. The FIFO ignores such an access, and the monitor records it as an underflow or an overflow together with a shared error bit. Software clears pending bits by writing ones to `pend_clr`. It freezes the byte count with `frz_set`, and reading the count (`cnt_rd`) releases the freeze.

Every flag, the count and the stored byte change on the clock edge that follows the cycle in which the event is presented.

Top module: `fifo_mon`

## Requirements
- R1: After reset, `byte_cnt`, `thr`, `data_buf`, `pend`, `frz`, `match`, `buf_full` and `buf_empty` are all zero.
- R2: When `upd` is high and the count is not frozen, `byte_cnt` takes the value of `q_len` one cycle later.
- R3: `frz_set` sets `frz` and `cnt_rd` clears it. While `frz` is high, `byte_cnt` holds its value through updates.
- R4: On `upd`, a match occurs when `mv_byte` equals `pat` on every bit where `mask` is 0. A match sets `match` and pending bit 0 (pattern).
- R5: On `upd` without a match, `match` is cleared and pending bit 0 keeps its value.
- R6: A threshold write (`thr_wr`) stores only `thr_data[6:0]` in `thr`.
- R7: When `upd` is high and `q_len` equals `thr`, pending bit 1 (count compare) is set.
- R8: When `thr_wr` is high and `q_len` equals the newly written 7-bit value, pending bit 1 is set.
- R9: On `upd`, `buf_full` and `buf_empty` take the values of `q_full` and `q_empty`. A full FIFO sets pending bit 2 and an empty FIFO sets pending bit 3.
- R10: `wr_try` while `q_full` sets pending bit 4 (overflow) and bit 6 (error). `rd_try` while `q_empty` sets bit 5 (underflow) and bit 6.
- R11: An illegal access without `upd` changes neither `byte_cnt` nor `data_buf`.
- R12: A one in `pend_clr` clears that pending bit. A set of the same bit in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| q_len | input | 7 | Current FIFO queue length |
| q_full | input | 1 | FIFO is full |
| q_empty | input | 1 | FIFO is empty |
| upd | input | 1 | FIFO completed a move in this cycle |
| mv_byte | input | 8 | Byte moved by that update |
| rd_try | input | 1 | Port attempts a FIFO read |
| wr_try | input | 1 | Port attempts a FIFO write |
| pat | input | 8 | Pattern value |
| mask | input | 8 | Don't-care mask (1 = ignore bit) |
| thr_wr | input | 1 | Threshold write strobe |
| thr_data | input | 8 | Threshold write data |
| frz_set | input | 1 | Freeze the byte count |
| cnt_rd | input | 1 | Byte count read; releases the freeze |
| pend_clr | input | 7 | Write-one-to-clear for pending bits |
| byte_cnt | output | 7 | Byte count |
| frz | output | 1 | Freeze state |
| thr | output | 7 | Stored threshold |
| data_buf | output | 8 | Last moved byte |
| match | output | 1 | Pattern match flag |
| buf_full | output | 1 | Full status seen at last update |
| buf_empty | output | 1 | Empty status seen at last update |
| pend | output | 7 | Pending bits: 0 pattern, 1 count, 2 full, 3 empty, 4 overflow, 5 underflow, 6 error |

## Verification
The pattern compare is tried with a byte that differs from the pattern only in masked bits. This shows that the mask is honoured and that the match flag and pending bit 0 are set. It is then tried with a byte that differs in an unmasked bit, which shows that a mismatch clears the flag but keeps pending bit 0.

The count compare is tried with a threshold whose bit 7 is set, which shows that only the low 7 bits are kept. The compare is then triggered once by a FIFO update and once by the threshold write alone, so the two trigger paths are told apart.

Illegal reads and writes are applied without an update, which separates the error events from a real count change. A clear is also applied in the same cycle as an overflow set, which shows that the set wins.

// File: rtl/fwm_pkg.sv
package fwm_pkg;
    localparam int NPEND = 7;
    localparam int P_PAT = 0;
    localparam int P_CMP = 1;
    localparam int P_FUL = 2;
    localparam int P_EMP = 3;
    localparam int P_OVF = 4;
    localparam int P_UNF = 5;
    localparam int P_ERR = 6;
endpackage

// File: rtl/fwm_match.sv
module fwm_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] data,
    input  logic [W-1:0] pat,
    input  logic [W-1:0] mask,
    output logic         hit
);
    always_comb begin
        hit = ((data ^ pat) & ~mask) == '0;
    end
endmodule

// File: rtl/fwm_cmp.sv
module fwm_cmp #(
    parameter int AW = 7,
    parameter int BW = 7
) (
    input  logic [AW-1:0] a,
    input  logic [BW-1:0] b,
    output logic          eq
);
    localparam int MW = (AW > BW) ? AW : BW;
    logic [MW-1:0] ax, bx;
    always_comb begin
        ax = MW'(a);
        bx = MW'(b);
        eq = (ax == bx);
    end
endmodule

// File: rtl/fifo_mon.sv
module fifo_mon
    import fwm_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    parameter int THR_W = 7,
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] q_len,
    input  logic             q_full,
    input  logic             q_empty,
    input  logic             upd,
    input  logic [DW-1:0]    mv_byte,
    input  logic             rd_try,
    input  logic             wr_try,
    input  logic [DW-1:0]    pat,
    input  logic [DW-1:0]    mask,
    input  logic             thr_wr,
    input  logic [DW-1:0]    thr_data,
    input  logic             frz_set,
    input  logic             cnt_rd,
    input  logic [NPEND-1:0] pend_clr,
    output logic [LEN_W-1:0] byte_cnt,
    output logic             frz,
    output logic [THR_W-1:0] thr,
    output logic [DW-1:0]    data_buf,
    output logic             match,
    output logic             buf_full,
    output logic             buf_empty,
    output logic [NPEND-1:0] pend
);
    typedef struct packed {
        logic [LEN_W-1:0] cnt;
        logic             frz;
        logic [THR_W-1:0] thr;
        logic [DW-1:0]    dbuf;
        logic             match;
        logic             bfull;
        logic             bempty;
        logic [NPEND-1:0] pend;
    } st_t;

    st_t st_d, st_q;
    logic pat_hit, len_eq_thr, len_eq_new;
    logic [THR_W-1:0] thr_new;

    assign thr_new = thr_data[THR_W-1:0];

    fwm_match #(.W(DW)) u_match (
        .data(mv_byte), .pat(pat), .mask(mask), .hit(pat_hit)
    );

    fwm_cmp #(.AW(LEN_W), .BW(THR_W)) u_cmp_upd (
        .a(q_len), .b(st_q.thr), .eq(len_eq_thr)
    );

    fwm_cmp #(.AW(LEN_W), .BW(THR_W)) u_cmp_wr (
        .a(q_len), .b(thr_new), .eq(len_eq_new)
    );

    always_comb begin
        logic [NPEND-1:0] set_v;
        st_d  = st_q;
        set_v = '0;

        if (frz_set)     st_d.frz = 1'b1;
        else if (cnt_rd) st_d.frz = 1'b0;

        if (thr_wr) begin
            st_d.thr = thr_new;
            if (len_eq_new) set_v[P_CMP] = 1'b1;
        end

        if (upd) begin
            if (!st_q.frz) st_d.cnt = q_len;
            st_d.dbuf   = mv_byte;
            st_d.match  = pat_hit;
            st_d.bfull  = q_full;
            st_d.bempty = q_empty;
            if (pat_hit)    set_v[P_PAT] = 1'b1;
            if (len_eq_thr) set_v[P_CMP] = 1'b1;
            if (q_full)     set_v[P_FUL] = 1'b1;
            if (q_empty)    set_v[P_EMP] = 1'b1;
        end

        if (wr_try && q_full) begin
            set_v[P_OVF] = 1'b1;
            set_v[P_ERR] = 1'b1;
        end
        if (rd_try && q_empty) begin
            set_v[P_UNF] = 1'b1;
            set_v[P_ERR] = 1'b1;
        end

        st_d.pend = (st_q.pend & ~pend_clr) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign byte_cnt  = st_q.cnt;
    assign frz       = st_q.frz;
    assign thr       = st_q.thr;
    assign data_buf  = st_q.dbuf;
    assign match     = st_q.match;
    assign buf_full  = st_q.bfull;
    assign buf_empty = st_q.bempty;
    assign pend      = st_q.pend;
endmodule

// File: rtl/fwm_chk.sv
module fwm_chk
    import fwm_pkg::*;
#(
    parameter int LEN_W = 7,
    parameter int DW    = 8,
    parameter int THR_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LEN_W-1:0] q_len,
    input logic             q_full,
    input logic             q_empty,
    input logic             upd,
    input logic [DW-1:0]    mv_byte,
    input logic             rd_try,
    input logic             wr_try,
    input logic [DW-1:0]    pat,
    input logic [DW-1:0]    mask,
    input logic             thr_wr,
    input logic [DW-1:0]    thr_data,
    input logic [LEN_W-1:0] byte_cnt,
    input logic             frz,
    input logic [THR_W-1:0] thr,
    input logic             match,
    input logic             buf_full,
    input logic [NPEND-1:0] pend
);
    a_r2_cnt_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !frz) |=> byte_cnt == $past(q_len));

    a_r3_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        frz |=> $stable(byte_cnt));

    a_r4_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && (((mv_byte ^ pat) & ~mask) == '0)) |=> (match && pend[P_PAT]));

    a_r5_mismatch_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && (((mv_byte ^ pat) & ~mask) != '0)) |=> !match);

    a_r6_thr_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> thr == $past(thr_data[THR_W-1:0]));

    a_r7_cmp_on_upd: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && (LEN_W'(thr) == q_len)) |=> pend[P_CMP]);

    a_r9_full_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && q_full) |=> (buf_full && pend[P_FUL]));

    a_r10_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_try && q_full) |=> (pend[P_OVF] && pend[P_ERR]));

    a_r10_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_try && q_empty) |=> (pend[P_UNF] && pend[P_ERR]));

    a_r11_no_count_move: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(byte_cnt));
endmodule

bind fifo_mon fwm_chk #(.LEN_W(LEN_W), .DW(DW), .THR_W(THR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .q_len(q_len), .q_full(q_full),
    .q_empty(q_empty), .upd(upd), .mv_byte(mv_byte), .rd_try(rd_try),
    .wr_try(wr_try), .pat(pat), .mask(mask), .thr_wr(thr_wr),
    .thr_data(thr_data), .byte_cnt(byte_cnt), .frz(frz), .thr(thr),
    .match(match), .buf_full(buf_full), .pend(pend)
);

// File: tb/tb_fifo_mon.sv
module tb_fifo_mon;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] q_len = '0;
    logic       q_full = 1'b0, q_empty = 1'b0, upd = 1'b0;
    logic [7:0] mv_byte = '0;
    logic       rd_try = 1'b0, wr_try = 1'b0;
    logic [7:0] pat = '0, mask = '0;
    logic       thr_wr = 1'b0;
    logic [7:0] thr_data = '0;
    logic       frz_set = 1'b0, cnt_rd = 1'b0;
    logic [6:0] pend_clr = '0;
    logic [6:0] byte_cnt, thr, pend;
    logic [7:0] data_buf;
    logic       frz, match, buf_full, buf_empty;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fifo_mon dut (
        .clk(clk), .rst_n(rst_n), .q_len(q_len), .q_full(q_full),
        .q_empty(q_empty), .upd(upd), .mv_byte(mv_byte), .rd_try(rd_try),
        .wr_try(wr_try), .pat(pat), .mask(mask), .thr_wr(thr_wr),
        .thr_data(thr_data), .frz_set(frz_set), .cnt_rd(cnt_rd),
        .pend_clr(pend_clr), .byte_cnt(byte_cnt), .frz(frz), .thr(thr),
        .data_buf(data_buf), .match(match), .buf_full(buf_full),
        .buf_empty(buf_empty), .pend(pend)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // drive at a falling edge; the effect is visible at the next falling edge
    task automatic step;
        @(negedge clk);
        upd = 0; rd_try = 0; wr_try = 0; thr_wr = 0;
        frz_set = 0; cnt_rd = 0; pend_clr = '0;
    endtask

    task automatic do_upd(input logic [6:0] len, input logic [7:0] b,
                          input logic f, input logic e);
        q_len = len; mv_byte = b; q_full = f; q_empty = e; upd = 1;
        step();
    endtask

    task automatic clear_all;
        pend_clr = 7'h7f;
        step();
    endtask

    task automatic t_reset;
        check("R1 byte_cnt", byte_cnt, 0);
        check("R1 thr", thr, 0);
        check("R1 pend", pend, 0);
        check("R1 flags", {frz, match, buf_full, buf_empty}, 0);
        check("R1 data_buf", data_buf, 0);
    endtask

    task automatic t_count;
        do_upd(7'd5, 8'h11, 0, 0);
        check("R2 count follows", byte_cnt, 5);
        check("R2 data_buf", data_buf, 8'h11);
    endtask

    task automatic t_freeze;
        frz_set = 1; step();
        check("R3 frz set", frz, 1);
        do_upd(7'd9, 8'h12, 0, 0);
        check("R3 frozen count", byte_cnt, 5);
        cnt_rd = 1; step();
        check("R3 frz cleared by read", frz, 0);
        do_upd(7'd10, 8'h13, 0, 0);
        check("R3 follows again", byte_cnt, 10);
    endtask

    task automatic t_match;
        clear_all();
        pat = 8'hA5; mask = 8'h0F;
        do_upd(7'd11, 8'hA3, 0, 0);
        check("R4 match flag", match, 1);
        check("R4 pattern pending", pend[0], 1);
        do_upd(7'd12, 8'hB5, 0, 0);
        check("R5 mismatch clears flag", match, 0);
        check("R5 pattern pending kept", pend[0], 1);
    endtask

    task automatic t_thr;
        clear_all();
        q_len = 7'd3; thr_data = 8'h85; thr_wr = 1; step();
        check("R6 threshold low bits", thr, 7'h05);
        check("R8 no compare when unequal", pend[1], 0);
        do_upd(7'd5, 8'h00, 0, 0);
        check("R7 compare on update", pend[1], 1);
        clear_all();
        check("R12 clear works", pend, 0);
        q_len = 7'd20; thr_data = 8'h14; thr_wr = 1; step();
        check("R8 compare on write", pend[1], 1);
    endtask

    task automatic t_full_empty;
        clear_all();
        do_upd(7'd64, 8'h01, 1, 0);
        check("R9 buf_full", buf_full, 1);
        check("R9 full pending", pend[2], 1);
        do_upd(7'd63, 8'h02, 0, 0);
        check("R9 buf_full follows", buf_full, 0);
        check("R9 full pending sticky", pend[2], 1);
        do_upd(7'd0, 8'h03, 0, 1);
        check("R9 buf_empty", buf_empty, 1);
        check("R9 empty pending", pend[3], 1);
    endtask

    task automatic t_illegal;
        clear_all();
        q_len = 0; q_empty = 1; q_full = 0; mv_byte = 8'hEE; rd_try = 1; step();
        check("R10 underflow+error", pend & 7'h70, 7'h60);
        check("R11 count kept on underflow", byte_cnt, 0);
        check("R11 data_buf kept", data_buf, 8'h03);
        clear_all();
        q_len = 7'd64; q_empty = 0; q_full = 1; wr_try = 1; step();
        check("R10 overflow+error", pend & 7'h70, 7'h50);
        check("R11 count kept on overflow", byte_cnt, 0);
    endtask

    task automatic t_clear;
        pend_clr = 7'h10; step();
        check("R12 overflow cleared", pend[4], 0);
        check("R12 error untouched", pend[6], 1);
        pend_clr = 7'h10; wr_try = 1; step();
        check("R12 set beats clear", pend[4], 1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        step();
        t_count();
        t_freeze();
        t_match();
        t_thr();
        t_full_empty();
        t_illegal();
        t_clear();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule